// File: doc/BRIEF.md
# Dual-Mode Receive Message FIFO

This block is the receive queue that sits behind a CAN / CAN FD acceptance stage. Each cycle the acceptance stage may offer one message element: a packed header word (identifier, format and type bits, data length code, receive timestamp, filter index and non-match marker) together with a payload of up to `MAXB` bytes. The FIFO stores accepted elements in arrival order. It shows the oldest element on its read port, and the host removes that element with a one-cycle acknowledge.

Configuration inputs set the active number of elements, a watermark level, the payload size per element, and the policy used when an element arrives while the FIFO is full. With the blocking policy the arriving element is dropped. With the overwrite policy the oldest element gives way to the new one. Four sticky event flags tell the host about new messages, the watermark, the full condition and lost messages. The host clears a flag by writing 1 to its bit.

Top module: `rx_msg_fifo`

## Requirements
- R1: After reset `fillLevel` is 0, `rdValid` is 0 and all four bits of `evtFlags` are 0.
- R2: Elements leave in the order they were stored. `rdHdr`/`rdData` show the oldest element whenever `rdValid` is 1. A cycle with `rdAck` high and `rdValid` high removes that element. `rdAck` on an empty FIFO has no effect. The header is passed through unchanged, with fields at id [28:0], extended-format 29, remote 30, error-state 31, DLC [35:32], bit-rate-switch 36, FD-format 37, non-match 38, filter index [45:39] and timestamp [61:46].
- R3: Every element that is stored sets `evtFlags[0]` (new message), and the flag stays set.
- R4: When a store raises the fill level from one below `cfgWatermark` to `cfgWatermark`, `evtFlags[1]` is set. A `cfgWatermark` of 0 never sets it.
- R5: When a store raises the fill level to `cfgDepth`, `evtFlags[2]` is set.
- R6: Blocking policy (`cfgOverwrite`=0): a write while full with no acknowledge in the same cycle is discarded. The level and the contents stay unchanged, and `evtFlags[3]` is set.
- R7: Overwrite policy (`cfgOverwrite`=1): a write while full drops the oldest element and stores the new one. The level stays unchanged and `evtFlags[3]` is not set.
- R8: A write and an acknowledge in the same cycle leave the level unchanged. This holds when the FIFO is full under either policy, and the write is stored.
- R9: A 1 in a bit of `evtClear` clears that flag and a 0 leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R10: `cfgSizeCode` values 0..7 select 8, 12, 16, 20, 24, 32, 48 and 64 payload bytes. Payload bytes at or above the selected size are stored as zero.
- R11: `cfgDepth` (1..`DEPTH`, changed only in reset) is the active number of elements: `fillLevel` never exceeds it, and reaching it counts as full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgDepth | input | CW | Active number of elements |
| cfgWatermark | input | CW | Watermark level, 0 disables |
| cfgOverwrite | input | 1 | 0 blocking, 1 overwrite when full |
| cfgSizeCode | input | 3 | Payload size code |
| wrValid | input | 1 | Element offered this cycle |
| wrHdr | input | 62 | Header of offered element |
| wrData | input | 8*MAXB | Payload of offered element, byte 0 in bits [7:0] |
| rdValid | output | 1 | Head element present |
| rdHdr | output | 62 | Header of head element |
| rdData | output | 8*MAXB | Payload of head element |
| rdAck | input | 1 | Pop head element |
| fillLevel | output | CW | Number of stored elements |
| evtFlags | output | 4 | Sticky events: 0 new, 1 watermark, 2 full, 3 lost |
| evtClear | input | 4 | Write-1 clear of event flags |

## Verification
The bench uses the defaults `DEPTH`=4 and `MAXB`=64. Four elements are then enough to reach full, and every size code, up to the whole 64-byte payload, can be seen on `rdData`. The bench also sets `cfgDepth` to 2, which checks that the full condition and pointer wrap follow the programmed depth rather than the storage size. Watermarks of 0, 1 and 2 cover the disabled case and the event firing on an early level.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Header layout of one stored message element (LSB first: id upward)
  typedef struct packed {
    logic [15:0] ts;
    logic [6:0]  fidx;
    logic        anmf;
    logic        fdf;
    logic        brs;
    logic [3:0]  dlc;
    logic        esi;
    logic        rtr;
    logic        xtd;
    logic [28:0] id;
  } rxHdr_t;

  localparam int HDR_W = $bits(rxHdr_t);

  // Control to datapath strobes
  typedef struct packed {
    logic store;  // write offered element at write pointer
    logic pop;    // advance read pointer (host ack or overwrite drop)
  } fifoStrobe_t;

  // Payload bytes selected by the size code
  function automatic logic [7:0] payloadBytes(input logic [2:0] code);
    case (code)
      3'd0: return 8'd8;
      3'd1: return 8'd12;
      3'd2: return 8'd16;
      3'd3: return 8'd20;
      3'd4: return 8'd24;
      3'd5: return 8'd32;
      3'd6: return 8'd48;
      default: return 8'd64;
    endcase
  endfunction

endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] cfgDepth,
  input  logic [CW-1:0] cfgWatermark,
  input  logic          cfgOverwrite,
  input  logic          wrValid,
  input  logic          rdAck,
  input  logic [3:0]    evtClear,
  output fifoStrobe_t   strobe,
  output logic [CW-1:0] fillLevel,
  output logic [3:0]    evtFlags
);

  logic [CW-1:0] level, levelNext;
  logic [3:0]    flags, setMask;
  logic          isFull, ackOk, lostNow, grow, shrink;

  always_comb begin
    isFull       = (level == cfgDepth);
    ackOk        = rdAck && (level != '0);
    strobe.store = wrValid && (!isFull || ackOk || cfgOverwrite);
    strobe.pop   = ackOk || (wrValid && isFull && cfgOverwrite);
    lostNow      = wrValid && isFull && !ackOk && !cfgOverwrite;
    grow         = strobe.store && !strobe.pop;
    shrink       = strobe.pop && !strobe.store;
    levelNext    = level;
    if (grow)        levelNext = level + CW'(1);
    else if (shrink) levelNext = level - CW'(1);
    setMask[0] = strobe.store;
    setMask[1] = grow && (cfgWatermark != '0) && (levelNext == cfgWatermark);
    setMask[2] = grow && (levelNext == cfgDepth);
    setMask[3] = lostNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level <= '0;
      flags <= '0;
    end else begin
      level <= levelNext;
      flags <= (flags & ~evtClear) | setMask;
    end
  end

  assign fillLevel = level;
  assign evtFlags  = flags;

endmodule

// File: rtl/rxf_dpath.sv
module rxf_dpath
  import rxf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int MAXB  = 64,
  parameter int CW    = 3,
  parameter int AW    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CW-1:0]     cfgDepth,
  input  logic [2:0]        cfgSizeCode,
  input  fifoStrobe_t       strobe,
  input  logic [HDR_W-1:0]  wrHdr,
  input  logic [8*MAXB-1:0] wrData,
  output logic [HDR_W-1:0]  rdHdr,
  output logic [8*MAXB-1:0] rdData
);

  rxHdr_t            hdrMem  [DEPTH];
  logic [8*MAXB-1:0] dataMem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [7:0]        keepBytes;
  logic [8*MAXB-1:0] keepMask;

  assign keepBytes = payloadBytes(cfgSizeCode);

  // Per-byte keep mask: bytes beyond the selected size store as zero
  for (genvar b = 0; b < MAXB; b++) begin : g_mask
    assign keepMask[b*8 +: 8] = {8{8'(b) < keepBytes}};
  end

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (CW'(p) == cfgDepth - CW'(1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.store) wrPtr <= bump(wrPtr);
      if (strobe.pop)   rdPtr <= bump(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.store) begin
      hdrMem[wrPtr]  <= rxHdr_t'(wrHdr);
      dataMem[wrPtr] <= wrData & keepMask;
    end
  end

  assign rdHdr  = hdrMem[rdPtr];
  assign rdData = dataMem[rdPtr];

endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int MAXB  = 64,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CW-1:0]     cfgDepth,
  input  logic [CW-1:0]     cfgWatermark,
  input  logic              cfgOverwrite,
  input  logic [2:0]        cfgSizeCode,
  input  logic              wrValid,
  input  logic [HDR_W-1:0]  wrHdr,
  input  logic [8*MAXB-1:0] wrData,
  output logic              rdValid,
  output logic [HDR_W-1:0]  rdHdr,
  output logic [8*MAXB-1:0] rdData,
  input  logic              rdAck,
  output logic [CW-1:0]     fillLevel,
  output logic [3:0]        evtFlags,
  input  logic [3:0]        evtClear
);

  fifoStrobe_t strobe;

  rxf_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgDepth(cfgDepth), .cfgWatermark(cfgWatermark),
    .cfgOverwrite(cfgOverwrite), .wrValid(wrValid), .rdAck(rdAck),
    .evtClear(evtClear), .strobe(strobe), .fillLevel(fillLevel), .evtFlags(evtFlags)
  );

  rxf_dpath #(.DEPTH(DEPTH), .MAXB(MAXB), .CW(CW), .AW(AW)) u_dpath (
    .clk(clk), .rstN(rstN), .cfgDepth(cfgDepth), .cfgSizeCode(cfgSizeCode),
    .strobe(strobe), .wrHdr(wrHdr), .wrData(wrData), .rdHdr(rdHdr), .rdData(rdData)
  );

  assign rdValid = (fillLevel != '0);

endmodule

// File: rtl/rx_msg_fifo_chk.sv
module rx_msg_fifo_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic [CW-1:0] cfgDepth,
  input logic          cfgOverwrite,
  input logic          wrValid,
  input logic          rdAck,
  input logic [3:0]    evtClear,
  input logic [CW-1:0] fillLevel,
  input logic [3:0]    evtFlags
);

  a_r11_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= cfgDepth);

  a_r2_empty_ack: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == '0) && rdAck && !wrValid |=> (fillLevel == '0));

  a_r3_new_sets: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && (fillLevel != cfgDepth) |=> evtFlags[0]);

  a_r6_block_lost: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOverwrite && wrValid && !rdAck && (fillLevel == cfgDepth)
    |=> evtFlags[3] && $stable(fillLevel));

  a_r7_overwrite_level: assert property (@(posedge clk) disable iff (!rstN)
    cfgOverwrite && wrValid && (fillLevel == cfgDepth) |=> $stable(fillLevel));

  a_r8_level_step: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && rdAck && (fillLevel != '0) |=> $stable(fillLevel));

  a_r9_lost_sticky: assert property (@(posedge clk) disable iff (!rstN)
    evtFlags[3] && !evtClear[3] |=> evtFlags[3]);

endmodule

bind rx_msg_fifo rx_msg_fifo_chk #(.CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .cfgDepth(cfgDepth), .cfgOverwrite(cfgOverwrite),
  .wrValid(wrValid), .rdAck(rdAck), .evtClear(evtClear),
  .fillLevel(fillLevel), .evtFlags(evtFlags)
);

// File: tb/tb_rx_msg_fifo.sv
module tb_rx_msg_fifo;
  localparam int DEPTH = 4;
  localparam int MAXB  = 64;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int HW    = 62;
  localparam int DW    = 8 * MAXB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] cfgDepth = CW'(4), cfgWatermark = '0;
  logic cfgOverwrite = 1'b0;
  logic [2:0] cfgSizeCode = 3'd7;
  logic wrValid = 1'b0, rdAck = 1'b0, rdValid;
  logic [HW-1:0] wrHdr = '0, rdHdr;
  logic [DW-1:0] wrData = '0, rdData;
  logic [CW-1:0] fillLevel;
  logic [3:0] evtFlags, evtClear = '0;

  int checks = 0, errors = 0, nextId = 1;

  always #4 clk = ~clk;

  rx_msg_fifo #(.DEPTH(DEPTH), .MAXB(MAXB)) dut (.*);

  // {wr, ack, clear[3:0], expected level[2:0], expected flags[3:0]}
  localparam logic [12:0] VEC [15] = '{
    {1'b1, 1'b0, 4'b0000, 3'd1, 4'b0001},  // R3 store
    {1'b1, 1'b0, 4'b0000, 3'd2, 4'b0011},  // R4 watermark 2
    {1'b0, 1'b0, 4'b1111, 3'd2, 4'b0000},  // R9 clear all
    {1'b1, 1'b0, 4'b0000, 3'd3, 4'b0001},
    {1'b1, 1'b0, 4'b0000, 3'd4, 4'b0101},  // R5 full
    {1'b1, 1'b0, 4'b0000, 3'd4, 4'b1101},  // R6 lost
    {1'b1, 1'b1, 4'b0000, 3'd4, 4'b1101},  // R8 write+ack while full
    {1'b0, 1'b0, 4'b1111, 3'd4, 4'b0000},
    {1'b0, 1'b1, 4'b0000, 3'd3, 4'b0000},
    {1'b0, 1'b1, 4'b0000, 3'd2, 4'b0000},  // R4 no event when draining
    {1'b0, 1'b1, 4'b0000, 3'd1, 4'b0000},
    {1'b0, 1'b1, 4'b0000, 3'd0, 4'b0000},
    {1'b0, 1'b1, 4'b0000, 3'd0, 4'b0000},  // R2 ack on empty
    {1'b1, 1'b1, 4'b0000, 3'd1, 4'b0001},  // R2 ack ignored, write stored
    {1'b1, 1'b0, 4'b0001, 3'd2, 4'b0011}   // R9 set beats clear
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input int depth, input int wm, input logic ovw, input logic [2:0] code);
    @(negedge clk);
    rstN = 1'b0;
    cfgDepth = CW'(depth); cfgWatermark = CW'(wm);
    cfgOverwrite = ovw; cfgSizeCode = code;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // One cycle of stimulus; outputs sampled 1 ns after the edge
  task automatic cyc(input logic wr, input logic ack, input logic [3:0] clr,
                     input logic [HW-1:0] hdr, input logic [DW-1:0] data);
    @(negedge clk);
    wrValid = wr; rdAck = ack; evtClear = clr; wrHdr = hdr; wrData = data;
    @(posedge clk);
    #1;
    wrValid = 1'b0; rdAck = 1'b0; evtClear = '0;
  endtask

  task automatic push(input int id);
    cyc(1'b1, 1'b0, 4'b0, HW'(id), '0);
  endtask

  function automatic logic [DW-1:0] byteMask(input int n);
    return (DW'(1) << (n * 8)) - DW'(1);
  endfunction

  initial begin
    doReset(4, 2, 1'b0, 3'd7);
    @(negedge clk);
    chk("R1 level after reset", DW'(fillLevel), '0);
    chk("R1 flags after reset", DW'(evtFlags), '0);
    chk("R1 rdValid after reset", DW'(rdValid), '0);

    for (int i = 0; i < 15; i++) begin
      cyc(VEC[i][12], VEC[i][11], VEC[i][10:7], HW'(nextId), '0);
      nextId++;
      chk($sformatf("R2 R3 R4 R5 R6 R8 R9 table %0d level", i), DW'(fillLevel), DW'(VEC[i][6:4]));
      chk($sformatf("R3 R4 R5 R6 R8 R9 table %0d flags", i), DW'(evtFlags), DW'(VEC[i][3:0]));
    end

    // Overwrite policy, watermark disabled
    doReset(4, 0, 1'b1, 3'd7);
    for (int i = 1; i <= 5; i++) push(i);
    chk("R7 level after overwrite", DW'(fillLevel), DW'(4));
    chk("R7 R4 flags no lost, no watermark", DW'(evtFlags), DW'(4'b0101));
    for (int i = 2; i <= 5; i++) begin
      chk($sformatf("R7 R2 head order %0d", i), DW'(rdHdr[28:0]), DW'(i));
      cyc(1'b0, 1'b1, 4'b0, '0, '0);
    end
    chk("R2 empty after drain", DW'(rdValid), '0);

    // Blocking policy with programmed depth 2
    doReset(2, 0, 1'b0, 3'd7);
    push(10); push(11); push(12);
    chk("R11 level at depth 2", DW'(fillLevel), DW'(2));
    chk("R11 R6 flags full and lost", DW'(evtFlags), DW'(4'b1101));
    chk("R6 head kept", DW'(rdHdr[28:0]), DW'(10));
    cyc(1'b0, 1'b1, 4'b0, '0, '0);
    chk("R6 second element kept", DW'(rdHdr[28:0]), DW'(11));
    push(13);
    cyc(1'b0, 1'b1, 4'b0, '0, '0);
    chk("R11 pointer wrap at depth 2", DW'(rdHdr[28:0]), DW'(13));

    // Header pass-through with watermark 1
    doReset(4, 1, 1'b0, 3'd7);
    cyc(1'b1, 1'b0, 4'b0, {16'hBEEF, 7'h55, 1'b1, 1'b1, 1'b0, 4'hA, 1'b1, 1'b0, 1'b1, 29'h1234567}, '0);
    chk("R2 header pass-through", DW'(rdHdr),
        DW'({16'hBEEF, 7'h55, 1'b1, 1'b1, 1'b0, 4'hA, 1'b1, 1'b0, 1'b1, 29'h1234567}));
    chk("R4 watermark 1 on first store", DW'(evtFlags), DW'(4'b0011));

    // Payload size codes
    begin
      int sizes[4] = '{8, 12, 32, 64};
      logic [2:0] codes[4] = '{3'd0, 3'd1, 3'd5, 3'd7};
      for (int k = 0; k < 4; k++) begin
        doReset(4, 0, 1'b0, codes[k]);
        cyc(1'b1, 1'b0, 4'b0, '0, '1);
        chk($sformatf("R10 payload code %0d", codes[k]), rdData, byteMask(sizes[k]));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule